// File: doc/BRIEF.md
# I2C Slave Receiver with Address Match

This block is a write-only I2C slave that runs entirely from a fast system clock. It oversamples the open-drain SCL and SDA lines, finds START and STOP conditions, and shifts each incoming byte in MSB first. After a START it compares the upper seven bits of the first byte with a programmable 7-bit address. On a match it takes in the address byte and every following data byte into a one-byte receive buffer.

It acknowledges a byte only when the buffer can take it. If the buffer is still full, or an overflow is still pending, it leaves SDA released for the acknowledge slot and keeps the old buffer contents. The interrupt flag is raised in both cases. The host side is a set of level outputs and single-cycle clear strobes. A host read clears the buffer-full flag. Overflow and interrupt each have their own clear strobe.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset, buf_full_o, ovf_o, irq_o, start_o, stop_o and sda_pull_o are all 0.
- R2: With en_i high, SDA falling while SCL is high is a START: start_o becomes 1 and stop_o becomes 0. SDA rising while SCL is high is a STOP: stop_o becomes 1 and start_o becomes 0.
- R3: After a START, eight bits are sampled MSB first on SCL rising edges. On the eighth SCL falling edge, bits 7..1 are compared with addr_i. On a match with buf_full_o and ovf_o both 0, the byte is copied to rx_data_o, buf_full_o is set, and SDA is pulled low for the ninth clock.
- R4: irq_o is set on the ninth SCL falling edge of every byte that was accepted or refused. It stays set until irq_clr_i.
- R5: Data bytes that follow a matched address are acknowledged and buffered under the same rules as R3.
- R6: If buf_full_o or ovf_o is 1 when a byte completes, SDA is not pulled, rx_data_o is unchanged and irq_o is still set. If buf_full_o was 1, ovf_o is set.
- R7: A one-cycle rd_i pulse clears buf_full_o and leaves ovf_o as it is. Only ovf_clr_i clears ovf_o.
- R8: On an address mismatch, no acknowledge is given. Further bytes are ignored until the next START or STOP, and buf_full_o, ovf_o, irq_o and rx_data_o stay unchanged.
- R9: Address byte 0x00 gets no special treatment. It is acknowledged only when addr_i is 0.
- R10: With irq_se_i = 1, every START and every STOP also sets irq_o. With irq_se_i = 0, they do not.
- R11: sda_pull_o = 1 means SDA is pulled low. It is 1 only in the acknowledge slot of an accepted byte, so the block never drives SDA during data bits.
- R12: While en_i is 0, bus activity is ignored: no acknowledge is given, and no flag or status output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| addr_i | input | 7 | Own slave address |
| irq_se_i | input | 1 | When 1, START and STOP also raise irq_o |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rx_data_o | output | 8 | Receive buffer |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| ovf_o | output | 1 | A byte arrived while the buffer was full |
| irq_o | output | 1 | Interrupt flag |
| start_o | output | 1 | Last condition seen was a START |
| stop_o | output | 1 | Last condition seen was a STOP |
| rd_i | input | 1 | Host read strobe, clears buf_full_o |
| ovf_clr_i | input | 1 | Clears ovf_o |
| irq_clr_i | input | 1 | Clears irq_o |

## Verification
The bench sends the following transfers:
- A matched write whose bytes are drained between transfers. This shows normal acknowledge and buffering.
- A write whose data is left unread. This separates refusal caused by a full buffer from refusal caused only by a pending overflow.
- A wrong address followed by data. This shows that mismatched traffic leaves every flag and the buffer untouched.
- Address 0x00 sent against a nonzero address and against a zero address. This shows that general call gets no special handling.

START and STOP are issued with the interrupt mode both off and on. The same transfer is repeated with the block disabled.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];

  // idle bus reads high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
  import i2c_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              irq_se_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              rd_i,
  input  logic              ovf_clr_i,
  input  logic              irq_clr_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              start_o,
  output logic              stop_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sr_q, rx_q;
  logic              is_addr_q, pull_q, bf_q, ovf_q, irq_q, start_q, stop_q;
  logic              byte_done, addr_miss;

  assign byte_done = scl_fall_i && (cnt_q == CNT_W'(BYTE_W));
  assign addr_miss = is_addr_q && (sr_q[BYTE_W-1:1] != addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      sr_q      <= '0;
      rx_q      <= '0;
      is_addr_q <= 1'b0;
      pull_q    <= 1'b0;
      bf_q      <= 1'b0;
      ovf_q     <= 1'b0;
      irq_q     <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
    end else begin
      // host clears first so that same-cycle sets win
      if (rd_i)      bf_q  <= 1'b0;
      if (ovf_clr_i) ovf_q <= 1'b0;
      if (irq_clr_i) irq_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_SHIFT;
        cnt_q     <= '0;
        is_addr_q <= 1'b1;
        pull_q    <= 1'b0;
        start_q   <= 1'b1;
        stop_q    <= 1'b0;
        if (irq_se_i) irq_q <= 1'b1;
      end else if (stop_i) begin
        state_q <= ST_IDLE;
        pull_q  <= 1'b0;
        stop_q  <= 1'b1;
        start_q <= 1'b0;
        if (irq_se_i) irq_q <= 1'b1;
      end else begin
        unique case (state_q)
          ST_SHIFT: begin
            if (scl_rise_i) begin
              sr_q  <= {sr_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (byte_done) begin
              if (addr_miss) begin
                state_q <= ST_SKIP;
              end else begin
                state_q <= ST_ACK;
                if (!bf_q && !ovf_q) begin
                  rx_q   <= sr_q;
                  bf_q   <= 1'b1;
                  pull_q <= 1'b1;
                end else if (bf_q) begin
                  ovf_q <= 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              pull_q    <= 1'b0;
              irq_q     <= 1'b1;
              state_q   <= ST_SHIFT;
              cnt_q     <= '0;
              is_addr_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign rx_data_o  = rx_q;
  assign buf_full_o = bf_q;
  assign ovf_o      = ovf_q;
  assign irq_o      = irq_q;
  assign start_o    = start_q;
  assign stop_o     = stop_q;

  // R6
  buf_kept_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_q) |-> !$past(bf_q));
  // R6
  ovf_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(bf_q));
  // R11
  ack_only_on_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> bf_q);
  // R4
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(scl_fall_i || start_i || stop_i));
  // R7
  bf_clear_by_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bf_q) |-> $past(rd_i));
  // R2
  start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_q && stop_q));
endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
  import i2c_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              irq_se_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              start_o,
  output logic              stop_o,
  input  logic              rd_i,
  input  logic              ovf_clr_i,
  input  logic              irq_clr_i
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_rx_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .addr_i     (addr_i),
    .irq_se_i   (irq_se_i),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_i       (rd_i),
    .ovf_clr_i  (ovf_clr_i),
    .irq_clr_i  (irq_clr_i),
    .sda_pull_o (sda_pull_o),
    .rx_data_o  (rx_data_o),
    .buf_full_o (buf_full_o),
    .ovf_o      (ovf_o),
    .irq_o      (irq_o),
    .start_o    (start_o),
    .stop_o     (stop_o)
  );
endmodule

// File: tb/test_i2c_slave_rx.sv
module test_i2c_slave_rx;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] addr = 7'h2A;
  logic       irq_se = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       rd = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0;
  logic       sda_pull, bf, ovf, irq, st, sp;
  logic [7:0] rx;
  logic       sda_line;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit exp_q[$];
  bit obs_ack;
  event ack_ev;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_slave_rx i_i2c_slave_rx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .addr_i(addr), .irq_se_i(irq_se),
    .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull), .rx_data_o(rx),
    .buf_full_o(bf), .ovf_o(ovf), .irq_o(irq), .start_o(st), .stop_o(sp),
    .rd_i(rd), .ovf_clr_i(ovf_clr), .irq_clr_i(irq_clr)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  // driver: pushes the expected acknowledge, the monitor compares it
  task automatic send_byte(logic [7:0] b, bit exp_ack);
    bit early = 1'b0;
    exp_q.push_back(exp_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(Q);
      if (sda_pull) early = 1'b1;
      wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    obs_ack = ~sda_line;
    -> ack_ev;
    wq(Q); scl_m = 1'b0; wq(2*Q);
    chk("R11 no pull in data bits", early, 0);
  endtask

  initial begin : monitor
    forever begin
      @(ack_ev);
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else chk("R3/R5/R6/R8/R9/R12 ack", obs_ack, exp_q.pop_front());
    end
  end

  task automatic host_read();
    rd = 1'b1; wq(1); rd = 1'b0; wq(1);
  endtask
  task automatic clr_irq();
    irq_clr = 1'b1; wq(1); irq_clr = 1'b0; wq(1);
  endtask
  task automatic clr_ovf();
    ovf_clr = 1'b1; wq(1); ovf_clr = 1'b0; wq(1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=expired exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    wq(4);
    chk("R1 bf", bf, 0); chk("R1 ovf", ovf, 0); chk("R1 irq", irq, 0);
    chk("R1 start", st, 0); chk("R1 stop", sp, 0); chk("R1 pull", sda_pull, 0);
    rst_n = 1'b1; wq(2);
    en = 1'b1; wq(2);

    bus_start();
    chk("R2 start_o", st, 1); chk("R2 stop_o", sp, 0); chk("R10 no irq on start", irq, 0);
    send_byte(8'h54, 1'b1);
    chk("R3 rx", rx, 8'h54); chk("R3 bf", bf, 1); chk("R4 irq", irq, 1);
    host_read(); clr_irq();
    chk("R7 bf cleared", bf, 0); chk("R4 irq cleared", irq, 0);

    send_byte(8'hA5, 1'b1);
    chk("R5 rx", rx, 8'hA5); chk("R5 bf", bf, 1); chk("R5 irq", irq, 1);
    clr_irq();

    send_byte(8'h3C, 1'b0);
    chk("R6 rx kept", rx, 8'hA5); chk("R6 ovf", ovf, 1); chk("R6 irq", irq, 1);
    host_read(); clr_irq();
    chk("R7 bf after read", bf, 0); chk("R7 ovf kept", ovf, 1);

    send_byte(8'h11, 1'b0);
    chk("R6 rx kept ovf only", rx, 8'hA5); chk("R6 bf stays clear", bf, 0);
    chk("R6 irq ovf only", irq, 1);
    clr_ovf(); clr_irq();
    chk("R7 ovf cleared", ovf, 0);

    send_byte(8'h77, 1'b1);
    chk("R5 rx after ovf clear", rx, 8'h77);
    host_read(); clr_irq();
    bus_stop();
    chk("R2 stop_o", sp, 1); chk("R2 start_o cleared", st, 0);
    chk("R10 no irq on stop", irq, 0);

    bus_start();
    send_byte(8'h56, 1'b0);
    send_byte(8'h99, 1'b0);
    chk("R8 bf", bf, 0); chk("R8 irq", irq, 0); chk("R8 rx", rx, 8'h77); chk("R8 ovf", ovf, 0);

    bus_start();
    send_byte(8'h00, 1'b0);
    chk("R9 nonzero addr irq", irq, 0);
    bus_stop();

    addr = 7'h00;
    bus_start();
    send_byte(8'h00, 1'b1);
    chk("R9 rx zero", rx, 8'h00); chk("R9 bf", bf, 1);
    host_read(); clr_irq();
    bus_stop();

    irq_se = 1'b1;
    bus_start();
    chk("R10 irq on start", irq, 1);
    clr_irq();
    bus_stop();
    chk("R10 irq on stop", irq, 1);
    clr_irq();
    irq_se = 1'b0;

    en = 1'b0; wq(2);
    bus_start();
    chk("R12 start_o unchanged", st, 0); chk("R12 stop_o unchanged", sp, 1);
    send_byte(8'h00, 1'b0);
    chk("R12 irq", irq, 0); chk("R12 bf", bf, 0);
    bus_stop();

    wq(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule